// File: doc/BRIEF.md
# SECDED Block Decoder

This block is a small memory-walking controller that repairs a batch of fifteen protected message entries. Each entry is a 16-bit single-error-correcting, double-error-detecting codeword stored as two bytes in a byte-wide, single-ported, synchronous-read memory. The controller reads both bytes of an entry and folds the bits into a 4-bit syndrome and an overall parity bit. From these it decides whether the entry is clean, holds one flipped bit (which it repairs), or holds two flipped bits (which it can only flag). It then writes the 11 message bits back as a padded byte pair, with a two-bit error class in the top of the upper byte.

The controller shares the memory with a host through a start/done handshake. While `start` is high the host owns the memory and the controller stays silent. On the first clock edge that sees `start` low after it was high, the controller runs the whole batch. It raises `done` once the final byte has been written.

Codeword bit numbering: low byte bit k is position k, and high byte bit k is position 8+k. Message bits b1..b11 sit at positions 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15. Check bits sit at positions 1, 2, 4 and 8, and the overall parity bit sits at position 0.

Top module: `secded_decoder`

## Requirements
- R1: Entry i (0 to 14, ascending) uses five cycles. The first cycle after launch presents read address 64+2i. The next two cycles present 65+2i. Then comes a write to 94+2i, then a write to 95+2i. The first entry's read address appears in the cycle after the edge that sees `start` low following a high `start`.
- R2: `mem_we` is never high in a cycle that follows an edge where `start` was sampled high. Raising `start` mid-batch abandons the batch and returns the controller to idle.
- R3: A codeword with zero syndrome and even overall parity is written back with its message bits unchanged and class 2'b00.
- R4: A codeword with exactly one flipped bit at any of positions 1 to 15 is written back with the original message and class 2'b01.
- R5: A codeword whose only flipped bit is position 0 is written back with the message unchanged and class 2'b01.
- R6: A codeword with two flipped bits (nonzero syndrome, even parity) is written with class 2'b10, and its message bits are taken from the received positions without any correction.
- R7: The even output byte is {b8,b7,b6,b5,b4,b3,b2,b1}, MSB first. The odd output byte is {class[1:0], 3'b000, b11, b10, b9}. The value 2'b11 never appears as a class.
- R8: `done` rises in the cycle right after the last write, stays high with no writes until `start` is sampled high, and is low in the cycle after that edge.
- R9: During and right after reset, `done` and `mem_we` are low.
- R10: Every write lands in addresses 94 to 123. The two bytes of an entry are written in back-to-back cycles, even address first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | High: host owns memory; falling edge launches a batch |
| done | output | 1 | Batch finished, results in memory |
| mem_addr | output | 8 | Memory address for the read or write of this cycle |
| mem_we | output | 1 | Write enable for this cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, one cycle after its address |

## Verification
The bench covers every single-bit error position, including the lone overall-parity flip. A decoder that ignores position 0 would then report a clean class, and an off-by-one syndrome mapping would corrupt a neighbouring message bit. Double-error pairs, some of which include position 0, check that the decoder never "repairs" a word it cannot fix: a wrong decoder would flip a third bit and report class 01. An abort raised in mid-batch shows that writes stop right away, and a full rerun afterwards shows that the controller restarts from entry 0 rather than resuming. Per-cycle comparison of address and phase catches a read sampled one cycle early, which would decode the address byte instead of the data byte.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int CW_W   = 16;
  localparam int SYN_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    EC_CLEAN  = 2'b00,
    EC_FIXED  = 2'b01,
    EC_DOUBLE = 2'b10
  } err_class_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RLO, PH_RHI, PH_DEC, PH_WLO, PH_WHI
  } phase_t;
endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]  cw,
  output logic [SYN_W-1:0] syn,
  output logic             par
);
  logic [SYN_W-1:0] term [CW_W];

  // each set bit contributes its own position index
  for (genvar k = 0; k < CW_W; k++) begin : g_term
    assign term[k] = cw[k] ? SYN_W'(k) : '0;
  end

  always_comb begin
    syn = '0;
    for (int k = 0; k < CW_W; k++) syn = syn ^ term[k];
  end

  assign par = ^cw;
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  input  logic [SYN_W-1:0]  syn,
  input  logic              par,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  logic [CW_W-1:0] mask;
  logic [CW_W-1:0] fixed;
  err_class_t      cls;

  always_comb begin
    mask = '0;
    cls  = EC_CLEAN;
    if (syn != '0) begin
      if (par) begin
        mask[syn] = 1'b1;
        cls       = EC_FIXED;
      end else begin
        cls = EC_DOUBLE;
      end
    end else if (par) begin
      cls = EC_FIXED;       // only the overall parity bit was hit
    end
  end

  assign fixed   = cw ^ mask;
  assign lo_byte = {fixed[12:9], fixed[7:5], fixed[3]};
  assign hi_byte = {cls, 3'b000, fixed[15:13]};
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
#(
  parameter int N_WORDS  = 15,
  parameter int ADDR_W   = 8,
  parameter int SRC_BASE = 64,
  parameter int DST_BASE = 94
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(N_WORDS - 1);
  localparam logic [ADDR_W-1:0] SRC_A = ADDR_W'(SRC_BASE);
  localparam logic [ADDR_W-1:0] DST_A = ADDR_W'(DST_BASE);

  phase_t            ph;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_nx;
  logic              start_q;
  logic [7:0]        lo_q;
  logic [7:0]        hi_q;
  logic [ADDR_W-1:0] off_cur;
  logic [ADDR_W-1:0] off_nx;

  logic [CW_W-1:0]  cw;
  logic [SYN_W-1:0] syn;
  logic             par;
  logic [7:0]       fix_lo;
  logic [7:0]       fix_hi;

  assign idx_nx  = idx + IDX_W'(1);
  assign off_cur = ADDR_W'({idx, 1'b0});
  assign off_nx  = ADDR_W'({idx_nx, 1'b0});
  assign cw      = {mem_rdata, lo_q};

  secded_syndrome syn_i (.cw(cw), .syn(syn), .par(par));

  secded_fix fix_i (
    .cw(cw), .syn(syn), .par(par), .lo_byte(fix_lo), .hi_byte(fix_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      idx       <= '0;
      start_q   <= 1'b0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
    end else begin
      start_q <= start;
      if (start) begin
        ph     <= PH_IDLE;
        mem_we <= 1'b0;
        done   <= 1'b0;
      end else begin
        case (ph)
          PH_IDLE: if (start_q) begin
            ph       <= PH_RLO;
            idx      <= '0;
            mem_addr <= SRC_A;
          end
          PH_RLO: begin
            mem_addr <= mem_addr + ADDR_W'(1);
            ph       <= PH_RHI;
          end
          PH_RHI: begin
            lo_q <= mem_rdata;
            ph   <= PH_DEC;
          end
          PH_DEC: begin
            hi_q      <= fix_hi;
            mem_wdata <= fix_lo;
            mem_we    <= 1'b1;
            mem_addr  <= DST_A + off_cur;
            ph        <= PH_WLO;
          end
          PH_WLO: begin
            mem_wdata <= hi_q;
            mem_addr  <= mem_addr + ADDR_W'(1);
            ph        <= PH_WHI;
          end
          PH_WHI: begin
            mem_we <= 1'b0;
            if (idx == LAST) begin
              done <= 1'b1;
              ph   <= PH_IDLE;
            end else begin
              idx      <= idx_nx;
              mem_addr <= SRC_A + off_nx;
              ph       <= PH_RLO;
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/secded_decoder_chk.sv
module secded_decoder_chk #(
  parameter int ADDR_W   = 8,
  parameter int N_WORDS  = 15,
  parameter int DST_BASE = 94
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [7:0]        mem_wdata
);
  logic [ADDR_W-1:0] off;
  assign off = mem_addr - ADDR_W'(DST_BASE);

  a_r2_quiet_under_start: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> !mem_we);

  a_r10_write_window: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(mem_addr) >= DST_BASE && int'(mem_addr) < DST_BASE + 2 * N_WORDS));

  a_r10_pair_order: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !off[0] && !start) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r7_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (mem_we && off[0]) |-> (mem_wdata[5:3] == 3'b000));

  a_r7_class_legal: assert property (@(posedge clk) disable iff (rst)
    (mem_we && off[0]) |-> (mem_wdata[7:6] != 2'b11));

  a_r8_done_silent: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);

  a_r8_done_clear: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> !done);
endmodule

bind secded_decoder secded_decoder_chk #(
  .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .DST_BASE(DST_BASE)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/secded_decoder_tb_top.sv
module secded_decoder_tb_top;
  localparam int NW = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       done;
  logic [7:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;

  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] mem [256];

  logic [15:0] cwv  [NW];
  logic [15:0] expv [NW];
  string       tagv [NW];
  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  secded_decoder dut_i (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // encoder built from the parity equations of the code
  function automatic logic [15:0] enc(input logic [10:0] m);
    logic [15:0] c;
    c = '0;
    c[3] = m[0]; c[5] = m[1]; c[6] = m[2]; c[7] = m[3];
    c[15:9] = m[10:4];
    c[8] = ^m[10:4];
    c[4] = m[10]^m[9]^m[8]^m[7]^m[3]^m[2]^m[1];
    c[2] = m[10]^m[9]^m[6]^m[5]^m[3]^m[2]^m[0];
    c[1] = m[10]^m[8]^m[6]^m[4]^m[3]^m[1]^m[0];
    c[0] = ^c[15:1];
    return c;
  endfunction

  // nearest-codeword search: {odd byte, even byte}
  function automatic logic [15:0] ref_out(input logic [15:0] rx);
    logic [10:0] best;
    logic [1:0]  cls;
    bit          hit;
    hit = 1'b0; best = '0; cls = 2'b10;
    for (int m = 0; m < 2048; m++) begin
      int d;
      d = $countones(enc(11'(m)) ^ rx);
      if (!hit && d <= 1) begin
        hit = 1'b1; best = 11'(m); cls = (d == 0) ? 2'b00 : 2'b01;
      end
    end
    if (!hit) best = {rx[15:9], rx[7:5], rx[3]};
    return {cls, 3'b000, best[10:8], best[7:0]};
  endfunction

  function automatic logic [10:0] next_msg();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[26:16];
  endfunction

  task automatic load_words();
    for (int w = 0; w < NW; w++) begin
      expv[w] = ref_out(cwv[w]);
      for (int b = 0; b < 2; b++) begin
        @(negedge clk);
        chk(mem_we == 1'b0, "R2", "we during load", int'(mem_we), 0);
        ld_en = 1'b1; ld_addr = 8'(64 + 2 * w + b);
        ld_data = (b == 0) ? cwv[w][7:0] : cwv[w][15:8];
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // abort_at < 0: full batch; otherwise raise start after that cycle
  task automatic run_batch(input int abort_at);
    start = 1'b0;
    for (int c = 0; c <= 5 * NW; c++) begin
      @(negedge clk);
      if (c == 5 * NW) begin
        chk(mem_we == 1'b0, "R8", "we after batch", int'(mem_we), 0);
        chk(done == 1'b1, "R8", "done after last write", int'(done), 1);
      end else begin
        int w, p;
        w = c / 5; p = c % 5;
        chk(done == 1'b0, "R8", "done while busy", int'(done), 0);
        chk(mem_we == (p >= 3), "R1", "we phase", int'(mem_we), int'(p >= 3));
        case (p)
          0: chk(mem_addr == 8'(64 + 2 * w), "R1", "low read addr", int'(mem_addr), 64 + 2 * w);
          1, 2: chk(mem_addr == 8'(65 + 2 * w), "R1", "high read addr", int'(mem_addr), 65 + 2 * w);
          3: begin
            chk(mem_addr == 8'(94 + 2 * w), "R10", "even write addr", int'(mem_addr), 94 + 2 * w);
            chk(mem_wdata == expv[w][7:0], {tagv[w], "/R7"}, "even byte", int'(mem_wdata), int'(expv[w][7:0]));
          end
          default: begin
            chk(mem_addr == 8'(95 + 2 * w), "R10", "odd write addr", int'(mem_addr), 95 + 2 * w);
            chk(mem_wdata == expv[w][15:8], {tagv[w], "/R7"}, "odd byte", int'(mem_wdata), int'(expv[w][15:8]));
          end
        endcase
      end
      if (c == abort_at) begin
        start = 1'b1;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk(mem_we == 1'b0, "R2", "we after abort", int'(mem_we), 0);
          chk(done == 1'b0, "R2", "done after abort", int'(done), 0);
        end
        return;
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b1 && mem_we == 1'b0, "R8", "done hold", int'(done), 1);
    end
    for (int w = 0; w < NW; w++) begin
      chk(mem[94 + 2 * w] == expv[w][7:0], {tagv[w], "/R7"}, "stored even", int'(mem[94 + 2 * w]), int'(expv[w][7:0]));
      chk(mem[95 + 2 * w] == expv[w][15:8], {tagv[w], "/R7"}, "stored odd", int'(mem[95 + 2 * w]), int'(expv[w][15:8]));
    end
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done cleared by start", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_we == 1'b0, "R9", "in reset", int'({done, mem_we}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && mem_we == 1'b0, "R9", "after reset", int'({done, mem_we}), 0);
    start = 1'b1;

    // clean words (R3)
    for (int w = 0; w < NW; w++) begin
      cwv[w] = enc((w == 0) ? 11'h555 : (w == 1) ? 11'h7FF : (w == 2) ? 11'h000 : next_msg());
      tagv[w] = "R3";
    end
    load_words(); run_batch(-1);

    // one flip at each position 1..15 (R4)
    for (int w = 0; w < NW; w++) begin
      cwv[w] = enc(next_msg()) ^ (16'h1 << (w + 1));
      tagv[w] = "R4";
    end
    load_words(); run_batch(-1);

    // overall parity only (R5), then double flips (R6)
    for (int w = 0; w < NW; w++) begin
      if (w == 0) begin
        cwv[w] = enc(next_msg()) ^ 16'h0001; tagv[w] = "R5";
      end else begin
        cwv[w] = enc(next_msg()) ^ (16'h1 << w) ^ (16'h1 << ((w + 7) % 16));
        tagv[w] = "R6";
      end
    end
    load_words(); run_batch(-1);

    // mixed batch, aborted mid-way (R2), then rerun from entry 0
    for (int w = 0; w < NW; w++) begin
      case (w % 3)
        0: begin cwv[w] = enc(next_msg()); tagv[w] = "R3"; end
        1: begin cwv[w] = enc(next_msg()) ^ (16'h1 << ((w * 5) % 16)); tagv[w] = ((w * 5) % 16 == 0) ? "R5" : "R4"; end
        default: begin cwv[w] = enc(next_msg()) ^ (16'h1 << (w % 16)) ^ (16'h1 << ((w + 1) % 16)); tagv[w] = "R6"; end
      endcase
    end
    load_words(); run_batch(10);
    load_words(); run_batch(-1);

    summary();
  end
endmodule